// File: doc/BRIEF.md
# Timer Interrupt Delivery and Status

This block sits behind a bank of eight timer channels and converts each channel's expiry pulse into an interrupt. Every channel owns a configuration word that picks one of three delivery paths. The first is a message: an address/data pair handed out on a valid/ready stream. The second is a one-cycle edge pulse on a numbered interrupt line. The third is a level assertion. A level assertion sets the channel's status bit and holds its line high until software clears the bit by writing a one to it.

Routing requests are checked against a fixed allowed-line mask, which software can read back in the upper half of the configuration word. A route that the mask does not allow is replaced by line 0, and line 0 means the channel is not routed. When a channel is reconfigured so that a pending level assertion would otherwise stay stuck, the status bit is dropped and its line released. The message stream follows the usual valid/ready rules. Once `msg_valid_o` is high, the address and data hold still until a cycle in which `msg_ready_i` is also high. Pending messages wait inside the block, one per channel. When several channels wait, the lowest-numbered channel goes first.

Top module: `tmr_irq_router`

## Requirements
- R1: An expiry on a channel whose enable bit (configuration bit 2) is clear produces no line activity, no status change and no message.
- R2: In level mode (configuration bit 1 set) with a valid non-zero route (bits 13:9), an expiry sets the channel's status bit and raises the routed line on the clock edge that samples the expiry, and both stay high until cleared.
- R3: In edge mode (bit 1 clear) an expiry raises the routed line for exactly one cycle on the edge that samples it, and leaves the status bit clear.
- R4: While a channel's status bit is set, a further expiry on that channel changes neither the status nor the lines.
- R5: Message delivery applies only when the channel is message-capable (read-only bit 15) and message-enable (bit 14) is set. The message address is bits 63:32 of the channel's message register and the data is bits 31:0. A channel with bit 14 set that is not capable uses the line path instead.
- R6: A route of 0 raises no line and sets no status, and line 0 is never driven.
- R7: A status write clears each status bit written as 1, together with its line. Bits written as 0 are unaffected.
- R8: A configuration write clears a set status bit and releases its old line if the new word disables the interrupt, enables message delivery, selects edge mode, or changes the route. A rewrite that keeps a level setup unchanged leaves the status set.
- R9: A requested route whose bit is clear in the allowed-line mask (read back in bits 63:32) is stored as 0.
- R10: If a status clear and a level expiry hit the same channel in the same cycle, the status bit stays set.
- R11: After reset all status bits, lines and `msg_valid_o` are 0, and every configuration word reads back with only its read-only fields set.
- R12: Waiting messages are offered one per handshake in ascending channel order. While `msg_ready_i` is low, the offered address and data hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| expire_i | input | NCH | Per-channel expiry pulses |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDXW | Channel addressed by the configuration write |
| cfg_wdata_i | input | 64 | Configuration word; read-only fields are ignored |
| cfg_ridx_i | input | IDXW | Channel whose configuration is read back |
| cfg_rdata_o | output | 64 | Configuration readback, including read-only fields |
| mreg_we_i | input | 1 | Message register write strobe |
| mreg_idx_i | input | IDXW | Channel addressed by the message register write |
| mreg_wdata_i | input | 64 | Message address (63:32) and data (31:0) |
| sts_clr_we_i | input | 1 | Status write strobe |
| sts_clr_i | input | NCH | Write-one-to-clear mask |
| sts_o | output | NCH | Status bits |
| line_o | output | NLINES | Registered interrupt lines |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted when high together with valid |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Line and status results appear on the clock edge that samples the expiry, the clear or the configuration write. The bench applies each stimulus for one cycle and checks at the following falling edge. An edge pulse is checked twice: high at that falling edge, and low one cycle later. A message is offered two edges after its expiry when the stream is idle. For this reason, message results are not checked at a fixed cycle. The expected pairs are queued, and a monitor compares each handshake as it happens. The bench also checks that the queue has drained after a bounded wait.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int LVL_BIT    = 1;
  localparam int EN_BIT     = 2;
  localparam int ROUTE_LO   = 9;
  localparam int ROUTE_W    = 5;
  localparam int MSGEN_BIT  = 14;
  localparam int MSGCAP_BIT = 15;
  localparam int ALLOW_LO   = 32;
  localparam int NLINES     = 1 << ROUTE_W;

  typedef struct packed {
    logic               lvl;
    logic               en;
    logic [ROUTE_W-1:0] route;
    logic               msgen;
  } chan_cfg_t;
endpackage

// File: rtl/irqd_cfg_bank.sv
module irqd_cfg_bank
  import irqd_pkg::*;
#(
  parameter int              NCH     = 8,
  parameter int              IDXW    = 3,
  parameter logic [NLINES-1:0] ALLOWED = 32'hFF00_0000,
  parameter logic [NCH-1:0]  MSG_CAP = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDXW-1:0]  idx,
  input  logic [63:0]      wdata,
  input  logic [IDXW-1:0]  ridx,
  output logic [63:0]      rdata,
  output chan_cfg_t        cfg_q  [NCH],
  output chan_cfg_t        cfg_nx [NCH],
  output logic [NCH-1:0]   drop
);
  logic [ROUTE_W-1:0] req_route;
  logic               route_ok;
  chan_cfg_t          wr_cfg;

  always_comb begin
    req_route    = wdata[ROUTE_LO +: ROUTE_W];
    route_ok     = (req_route == '0) || ALLOWED[req_route];
    wr_cfg.lvl   = wdata[LVL_BIT];
    wr_cfg.en    = wdata[EN_BIT];
    wr_cfg.msgen = wdata[MSGEN_BIT];
    wr_cfg.route = route_ok ? req_route : '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = we && (idx == IDXW'(c));

    always_comb begin
      cfg_nx[c] = hit ? wr_cfg : cfg_q[c];
      drop[c]   = hit && (!wr_cfg.en || (wr_cfg.msgen && MSG_CAP[c]) ||
                          !wr_cfg.lvl || (wr_cfg.route != cfg_q[c].route));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[c] <= '0;
      else        cfg_q[c] <= cfg_nx[c];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[ALLOW_LO +: NLINES] = ALLOWED;
    for (int c = 0; c < NCH; c++) begin
      if (ridx == IDXW'(c)) begin
        rdata[LVL_BIT]              = cfg_q[c].lvl;
        rdata[EN_BIT]               = cfg_q[c].en;
        rdata[ROUTE_LO +: ROUTE_W]  = cfg_q[c].route;
        rdata[MSGEN_BIT]            = cfg_q[c].msgen;
        rdata[MSGCAP_BIT]           = MSG_CAP[c];
      end
    end
  end
endmodule

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
#(
  parameter int             NCH     = 8,
  parameter logic [NCH-1:0] MSG_CAP = '1
) (
  input  logic [NCH-1:0] expire,
  input  chan_cfg_t      cfg    [NCH],
  input  logic [NCH-1:0] sts_q,
  output logic [NCH-1:0] lvl_set,
  output logic [NCH-1:0] pulse,
  output logic [NCH-1:0] msg_req
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic live, to_msg, to_line;
    always_comb begin
      live       = expire[c] && cfg[c].en && !sts_q[c];
      to_msg     = live && cfg[c].msgen && MSG_CAP[c];
      to_line    = live && !to_msg && (cfg[c].route != '0);
      msg_req[c] = to_msg;
      pulse[c]   = to_line && !cfg[c].lvl;
      lvl_set[c] = to_line && cfg[c].lvl;
    end
  end
endmodule

// File: rtl/irqd_status.sv
module irqd_status #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] drop,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] set,
  output logic [NCH-1:0] sts_q,
  output logic [NCH-1:0] sts_nx
);
  logic [NCH-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr : '0;
    sts_nx  = (sts_q & ~drop & ~clr_eff) | set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_nx;
  end
endmodule

// File: rtl/irqd_lines.sv
module irqd_lines
  import irqd_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    sts_nx,
  input  logic [NCH-1:0]    pulse,
  input  chan_cfg_t         cfg    [NCH],
  output logic [NLINES-1:0] line_q
);
  logic [NLINES-1:0] line_nx;

  always_comb begin
    line_nx = '0;
    for (int l = 1; l < NLINES; l++) begin
      for (int c = 0; c < NCH; c++) begin
        if ((sts_nx[c] || pulse[c]) && (cfg[c].route == ROUTE_W'(l)))
          line_nx[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_nx;
  end
endmodule

// File: rtl/irqd_msg_arb.sv
module irqd_msg_arb #(
  parameter int NCH  = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mreg_we,
  input  logic [IDXW-1:0] mreg_idx,
  input  logic [63:0]     mreg_wdata,
  input  logic [NCH-1:0]  req,
  output logic            valid,
  input  logic            ready,
  output logic [31:0]     addr,
  output logic [31:0]     data
);
  logic [63:0]    mreg [NCH];
  logic [NCH-1:0] pend, grant;
  logic           slot_free;
  logic [63:0]    pick;

  assign slot_free = !valid || ready;

  always_comb begin
    grant = '0;
    pick  = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend[c]) begin
        grant = '0;
        grant[c] = 1'b1;
        pick  = mreg[c];
      end
    end
    if (!slot_free) grant = '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) mreg[c] <= '0;
      else if (mreg_we && mreg_idx == IDXW'(c)) mreg[c] <= mreg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else begin
      pend <= (pend & ~grant) | req;
      if (slot_free) begin
        valid <= |pend;
        if (|pend) begin
          addr <= pick[63:32];
          data <= pick[31:0];
        end
      end
    end
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import irqd_pkg::*;
#(
  parameter int                NCH     = 8,
  parameter int                IDXW    = $clog2(NCH),
  parameter logic [NLINES-1:0] ALLOWED = 32'hFF00_0000,
  parameter logic [NCH-1:0]    MSG_CAP = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    expire_i,
  input  logic              cfg_we_i,
  input  logic [IDXW-1:0]   cfg_idx_i,
  input  logic [63:0]       cfg_wdata_i,
  input  logic [IDXW-1:0]   cfg_ridx_i,
  output logic [63:0]       cfg_rdata_o,
  input  logic              mreg_we_i,
  input  logic [IDXW-1:0]   mreg_idx_i,
  input  logic [63:0]       mreg_wdata_i,
  input  logic              sts_clr_we_i,
  input  logic [NCH-1:0]    sts_clr_i,
  output logic [NCH-1:0]    sts_o,
  output logic [NLINES-1:0] line_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [31:0]       msg_addr_o,
  output logic [31:0]       msg_data_o
);
  chan_cfg_t      cfg_q  [NCH];
  chan_cfg_t      cfg_nx [NCH];
  logic [NCH-1:0] drop, lvl_set, pulse, msg_req, sts_nx;

  irqd_cfg_bank #(.NCH(NCH), .IDXW(IDXW), .ALLOWED(ALLOWED), .MSG_CAP(MSG_CAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .idx(cfg_idx_i), .wdata(cfg_wdata_i),
    .ridx(cfg_ridx_i), .rdata(cfg_rdata_o), .cfg_q(cfg_q), .cfg_nx(cfg_nx), .drop(drop)
  );

  irqd_decode #(.NCH(NCH), .MSG_CAP(MSG_CAP)) u_dec (
    .expire(expire_i), .cfg(cfg_nx), .sts_q(sts_o),
    .lvl_set(lvl_set), .pulse(pulse), .msg_req(msg_req)
  );

  irqd_status #(.NCH(NCH)) u_sts (
    .clk(clk), .rst_n(rst_n), .drop(drop), .clr_we(sts_clr_we_i), .clr(sts_clr_i),
    .set(lvl_set), .sts_q(sts_o), .sts_nx(sts_nx)
  );

  irqd_lines #(.NCH(NCH)) u_lines (
    .clk(clk), .rst_n(rst_n), .sts_nx(sts_nx), .pulse(pulse), .cfg(cfg_nx), .line_q(line_o)
  );

  irqd_msg_arb #(.NCH(NCH), .IDXW(IDXW)) u_msg (
    .clk(clk), .rst_n(rst_n), .mreg_we(mreg_we_i), .mreg_idx(mreg_idx_i),
    .mreg_wdata(mreg_wdata_i), .req(msg_req), .valid(msg_valid_o), .ready(msg_ready_i),
    .addr(msg_addr_o), .data(msg_data_o)
  );
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
  import irqd_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    expire_i,
  input logic              sts_clr_we_i,
  input logic [NCH-1:0]    sts_clr_i,
  input logic [NCH-1:0]    sts_o,
  input logic [NLINES-1:0] line_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [31:0]       msg_addr_o,
  input logic [31:0]       msg_data_o,
  input logic [63:0]       cfg_rdata_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_sts_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_o[c]) |-> $past(expire_i[c]));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr_we_i && sts_clr_i[c] && !expire_i[c]) |=> !sts_o[c]);
  end

  assert_line_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_o[0]);

  assert_msg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  assert_route_allowed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata_o[ROUTE_LO +: ROUTE_W] != '0) |-> cfg_rdata_o[ALLOW_LO + int'(cfg_rdata_o[ROUTE_LO +: ROUTE_W])]);
endmodule

bind tmr_irq_router irqd_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .expire_i(expire_i), .sts_clr_we_i(sts_clr_we_i),
  .sts_clr_i(sts_clr_i), .sts_o(sts_o), .line_o(line_o), .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
  .cfg_rdata_o(cfg_rdata_o)
);

// File: tb/tmr_irq_router_test.sv
module tmr_irq_router_test;
  localparam int NCH = 8;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] expire = '0;
  logic cfg_we = 1'b0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [IDXW-1:0] cfg_ridx = '0;
  logic [63:0] cfg_rdata;
  logic mreg_we = 1'b0;
  logic [IDXW-1:0] mreg_idx = '0;
  logic [63:0] mreg_wdata = '0;
  logic clr_we = 1'b0;
  logic [NCH-1:0] clr = '0;
  logic [NCH-1:0] sts;
  logic [31:0] line;
  logic msg_valid, msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [63:0] exp_q[$];

  always #10 clk = ~clk;

  tmr_irq_router uut (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .cfg_ridx_i(cfg_ridx), .cfg_rdata_o(cfg_rdata),
    .mreg_we_i(mreg_we), .mreg_idx_i(mreg_idx), .mreg_wdata_i(mreg_wdata),
    .sts_clr_we_i(clr_we), .sts_clr_i(clr), .sts_o(sts), .line_o(line),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Field positions: level bit 1, enable bit 2, route 13:9, message enable 14.
  function automatic logic [63:0] cw(bit lvl, bit en, int route, bit msgen);
    logic [63:0] w = '0;
    w[1] = lvl; w[2] = en; w[13:9] = 5'(route); w[14] = msgen;
    return w;
  endfunction

  task automatic wr_cfg(int ch, logic [63:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = IDXW'(ch); cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_mreg(int ch, logic [63:0] w);
    @(negedge clk); mreg_we = 1'b1; mreg_idx = IDXW'(ch); mreg_wdata = w;
    @(negedge clk); mreg_we = 1'b0;
  endtask

  task automatic fire(logic [NCH-1:0] m);
    @(negedge clk); expire = m;
    @(negedge clk); expire = '0;
  endtask

  task automatic clear(logic [NCH-1:0] m);
    @(negedge clk); clr_we = 1'b1; clr = m;
    @(negedge clk); clr_we = 1'b0; clr = '0;
  endtask

  // Monitor: compares each handshake against the scoreboard queue.
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected message", {msg_addr, msg_data}, 64'hx);
      else chk("R5/R12 message", {msg_addr, msg_data}, exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 status", 64'(sts), 64'h0);
    chk("R11 lines", 64'(line), 64'h0);
    chk("R11 valid", 64'(msg_valid), 64'h0);
    cfg_ridx = 0; #1;
    chk("R11 readback ch0", cfg_rdata, 64'hFF00_0000_0000_8000);

    // R1: disabled channel
    wr_cfg(0, cw(1, 0, 24, 0));
    fire(8'h01);
    chk("R1 status", 64'(sts), 64'h0);
    chk("R1 lines", 64'(line), 64'h0);

    // R9: disallowed route 5 stored as 0, and then R6 no effect
    wr_cfg(1, cw(1, 1, 5, 0));
    cfg_ridx = 1; #1;
    chk("R9 readback", cfg_rdata, 64'hFF00_0000_0000_8006);
    fire(8'h02);
    chk("R6 forced route status", 64'(sts), 64'h0);
    wr_cfg(2, cw(1, 1, 0, 0));
    fire(8'h04);
    chk("R6 route zero lines", 64'(line), 64'h0);
    chk("R6 route zero status", 64'(sts), 64'h0);

    // R2: level assertion
    wr_cfg(0, cw(1, 1, 24, 0));
    fire(8'h01);
    chk("R2 status", 64'(sts), 64'h01);
    chk("R2 line", 64'(line), 64'h0100_0000);
    repeat (3) @(negedge clk);
    chk("R2 held", 64'(line), 64'h0100_0000);
    // R4: repeat expiry
    fire(8'h01);
    chk("R4 status", 64'(sts), 64'h01);
    chk("R4 line", 64'(line), 64'h0100_0000);
    // R7: zero write no effect, one write clears
    clear(8'h00);
    chk("R7 zero write", 64'(sts), 64'h01);
    clear(8'h01);
    chk("R7 clear status", 64'(sts), 64'h0);
    chk("R7 clear line", 64'(line), 64'h0);

    // R3: edge pulse
    wr_cfg(3, cw(0, 1, 25, 0));
    fire(8'h08);
    chk("R3 pulse", 64'(line), 64'h0200_0000);
    chk("R3 status", 64'(sts), 64'h0);
    @(negedge clk);
    chk("R3 pulse end", 64'(line), 64'h0);

    // R8: configuration changes
    fire(8'h01);
    wr_cfg(0, cw(1, 1, 24, 0));
    chk("R8 same rewrite", 64'(sts), 64'h01);
    wr_cfg(0, cw(1, 1, 26, 0));
    chk("R8 route change", 64'(sts), 64'h0);
    chk("R8 route change line", 64'(line), 64'h0);
    fire(8'h01);
    chk("R8 set on new route", 64'(line), 64'h0400_0000);
    wr_cfg(0, cw(0, 1, 26, 0));
    chk("R8 edge", 64'(sts), 64'h0);
    wr_cfg(0, cw(1, 1, 26, 0));
    fire(8'h01);
    wr_cfg(0, cw(1, 0, 26, 0));
    chk("R8 disable", 64'(sts), 64'h0);
    wr_cfg(0, cw(1, 1, 26, 0));
    fire(8'h01);
    wr_cfg(0, cw(1, 1, 26, 1));
    chk("R8 message", 64'(sts), 64'h0);
    chk("R8 message line", 64'(line), 64'h0);

    // R10: clear and expiry together
    wr_cfg(0, cw(1, 1, 24, 0));
    @(negedge clk); expire = 8'h01; clr_we = 1'b1; clr = 8'h01;
    @(negedge clk); expire = '0; clr_we = 1'b0; clr = '0;
    chk("R10 expiry wins", 64'(sts), 64'h01);
    clear(8'h01);

    // R5: message delivery
    wr_mreg(4, 64'h0000_0FEE_0000_0031);
    wr_cfg(4, cw(0, 1, 0, 1));
    exp_q.push_back(64'h0000_0FEE_0000_0031);
    fire(8'h10);
    chk("R5 no line", 64'(line), 64'h0);
    repeat (4) @(negedge clk);
    chk("R5 delivered", 64'(exp_q.size()), 64'h0);
    // R5: not capable channel 7 takes the line path
    wr_cfg(7, cw(0, 1, 27, 1));
    cfg_ridx = 7; #1;
    chk("R5 ch7 readback", cfg_rdata, 64'hFF00_0000_0000_7604);
    fire(8'h80);
    chk("R5 non-capable pulse", 64'(line), 64'h0800_0000);
    repeat (4) @(negedge clk);

    // R12: backpressure and order
    wr_mreg(5, 64'hAAAA_0005_1234_5005);
    wr_mreg(6, 64'hBBBB_0006_1234_6006);
    wr_cfg(5, cw(1, 1, 0, 1));
    wr_cfg(6, cw(0, 1, 0, 1));
    @(negedge clk); msg_ready = 1'b0;
    fire(8'h60);
    repeat (4) @(negedge clk);
    chk("R12 valid held", 64'(msg_valid), 64'h1);
    chk("R12 lowest first", {msg_addr, msg_data}, 64'hAAAA_0005_1234_5005);
    exp_q.push_back(64'hAAAA_0005_1234_5005);
    exp_q.push_back(64'hBBBB_0006_1234_6006);
    msg_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 drained", 64'(exp_q.size()), 64'h0);
    chk("R12 idle", 64'(msg_valid), 64'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule